// File: doc/BRIEF.md
# Seconds/Ticks Timekeeper with PPS Capture

This block keeps the time of day as a seconds count paired with a sub-second tick count. The tick count advances once per clock and rolls over into the seconds count at a programmable ticks-per-second value. A once-per-second pulse, taken from one of two pins, is brought into the clock domain through a synchronizer. Each selected edge of that pulse records the running time into a capture pair.

Software sets the block up through a small bank of write-only settings addressed by index. A new time can be placed into the counters at once, or held pending and applied on the next selected pulse edge, so that several units can step to the same second. A 32-bit readback port returns the running time and the last captured time at byte offsets 0, 4, 8 and 12.

Top module: `sectick_timekeeper`

## Requirements
- R1: While reset is high and in the cycle after it, the four readback words are 0; the pulse edge select and source select reset to 0 (falling edge, connector pin), the load mode resets to deferred, nothing is armed and ticks-per-second resets to the parameter RST_TPS.
- R2: The tick count rises by 1 per clock; when ticks are greater than or equal to ticks-per-second minus 1 they return to 0 and seconds rise by 1, wrapping modulo 2^SEC_W; a ticks-per-second of 0 means the full 2^TICK_W range and a value of 1 steps seconds every clock.
- R3: Settings index 0 takes the new seconds, index 1 the new ticks, index 2 the pulse mode, index 3 the load mode (bit 0), index 4 ticks-per-second; a write to index 0 while load mode bit 0 is 1 replaces seconds and ticks at that clock edge with the written seconds and the last written ticks.
- R4: A write to index 0 while load mode bit 0 is 0 arms a deferred load; time keeps counting until a selected pulse edge, and the running time equals the armed seconds and ticks after the third rising clock edge that follows the pin change.
- R5: Every selected pulse edge stores the running time of the cycle before that third clock edge into the capture pair, i.e. the ticks seen in the cycle the pin changed plus 2; the capture pair is otherwise unchanged.
- R6: Pulse mode bit 0 selects the edge: 1 captures on a rising pin, 0 on a falling pin; the other edge has no effect.
- R7: Pulse mode bit 1 selects the pin: 0 the connector pin `pps_conn`, 1 the unit-link pin `pps_link`; the unselected pin has no effect.
- R8: An armed load is consumed by one selected edge; later edges capture time but do not reload it.
- R9: A new index 0 write replaces any pending load: a deferred write rearms with the newest values, and an immediate write loads at once and cancels the pending one.
- R10: Writes to index 5 (unit-link sync setting) and to indices 6 and 7 change neither the running time nor the capture pair.
- R11: Readback bits [3:2] of `rb_addr` select running seconds (0), running ticks (1), captured seconds (2), captured ticks (3); bits [1:0] are ignored and narrower counts are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 3 | Settings index |
| cfg_wdata | input | 32 | Settings write data |
| pps_conn | input | 1 | Pulse from the external connector (asynchronous) |
| pps_link | input | 1 | Pulse from the multi-unit link (asynchronous) |
| rb_addr | input | 4 | Readback byte offset |
| rb_data | output | 32 | Readback word |

## Verification
The bench walks rollover points: exactly at ticks-per-second minus 1, a load above the rollover, ticks-per-second of 1 and of 0, and seconds wrapping to 0; a design with an equality compare would run past an oversized tick load, and one that used the rollover value itself would show one tick too many per second. Deferred loads are checked at the exact cycle after a pulse, with the capture value pinned to the pin-change cycle plus two, so a missing or extra synchronizer stage shows up as an off-by-one. It also fires second pulses after a load, wrong-polarity edges, edges on the unselected pin, rearms and cancelling immediate loads. A design that reloaded on every pulse, took the wrong pin, or let a stale arm survive would read back a different time.

// File: rtl/sectick_pkg.sv
package sectick_pkg;
   // Settings indices; software drivers decode this order.
   typedef enum logic [2:0] {
      IDX_SEC   = 3'd0,
      IDX_TICK  = 3'd1,
      IDX_MODE  = 3'd2,
      IDX_IMM   = 3'd3,
      IDX_TPS   = 3'd4,
      IDX_LINK  = 3'd5
   } cfg_idx_e;

   localparam int MODE_EDGE_BIT = 0;
   localparam int MODE_SRC_BIT  = 1;
   localparam int NUM_PINS      = 2;

   typedef struct packed {
      logic use_link;
      logic on_rise;
   } pps_mode_t;
endpackage

// File: rtl/sectick_pps_detect.sv
module sectick_pps_detect
   import sectick_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] pins,
   input  pps_mode_t           mode,
   output logic                edge_evt
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] synced;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= {chain[SYNC_STAGES-2:0], pins[g]};
      end
      assign synced[g] = chain[SYNC_STAGES-1];
   end

   logic sel_now, sel_prev;
   assign sel_now = mode.use_link ? synced[1] : synced[0];

   always_ff @(posedge clk) begin
      if (rst) sel_prev <= 1'b0;
      else     sel_prev <= sel_now;
   end

   always_comb begin
      if (mode.on_rise) edge_evt = sel_now & ~sel_prev;
      else              edge_evt = ~sel_now & sel_prev;
   end
endmodule

// File: rtl/sectick_cfg_regs.sv
module sectick_cfg_regs
   import sectick_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          SEC_W   = 32,
   parameter int          TICK_W  = 32,
   parameter logic [TICK_W-1:0] RST_TPS = TICK_W'(100_000_000)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [2:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic              sec_wr,
   output logic [SEC_W-1:0]  sec_val,
   output logic [TICK_W-1:0] tick_val,
   output logic              imm,
   output logic [TICK_W-1:0] tps,
   output pps_mode_t         mode
);
   assign sec_wr  = we && (idx == IDX_SEC);
   assign sec_val = wdata[SEC_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_val <= '0;
         imm      <= 1'b0;
         tps      <= RST_TPS;
         mode     <= '0;
      end else if (we) begin
         case (idx)
            IDX_TICK: tick_val <= wdata[TICK_W-1:0];
            IDX_MODE: begin
               mode.on_rise  <= wdata[MODE_EDGE_BIT];
               mode.use_link <= wdata[MODE_SRC_BIT];
            end
            IDX_IMM:  imm <= wdata[0];
            IDX_TPS:  tps <= wdata[TICK_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sectick_time_core.sv
module sectick_time_core #(
   parameter int SEC_W  = 32,
   parameter int TICK_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sec_wr,
   input  logic [SEC_W-1:0]  sec_val,
   input  logic [TICK_W-1:0] tick_val,
   input  logic              imm,
   input  logic [TICK_W-1:0] tps,
   input  logic              pps_evt,
   output logic [SEC_W-1:0]  now_sec,
   output logic [TICK_W-1:0] now_ticks,
   output logic [SEC_W-1:0]  cap_sec,
   output logic [TICK_W-1:0] cap_ticks,
   output logic              armed
);
   logic [SEC_W-1:0]  pend_sec;
   logic [TICK_W-1:0] pend_ticks;
   logic              tick_last;

   always_comb begin
      if (tps == '0) tick_last = &now_ticks;
      else           tick_last = (now_ticks >= tps - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         now_sec    <= '0;
         now_ticks  <= '0;
         cap_sec    <= '0;
         cap_ticks  <= '0;
         pend_sec   <= '0;
         pend_ticks <= '0;
         armed      <= 1'b0;
      end else begin
         if (sec_wr && imm) begin
            now_sec   <= sec_val;
            now_ticks <= tick_val;
         end else if (pps_evt && armed) begin
            now_sec   <= pend_sec;
            now_ticks <= pend_ticks;
         end else if (tick_last) begin
            now_sec   <= now_sec + 1'b1;
            now_ticks <= '0;
         end else begin
            now_ticks <= now_ticks + 1'b1;
         end

         if (sec_wr) begin
            pend_sec   <= sec_val;
            pend_ticks <= tick_val;
            armed      <= ~imm;
         end else if (pps_evt) begin
            armed      <= 1'b0;
         end

         if (pps_evt) begin
            cap_sec   <= now_sec;
            cap_ticks <= now_ticks;
         end
      end
   end
endmodule

// File: rtl/sectick_timekeeper.sv
module sectick_timekeeper
   import sectick_pkg::*;
#(
   parameter int SEC_W       = 32,
   parameter int TICK_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter logic [TICK_W-1:0] RST_TPS = TICK_W'(100_000_000)
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_idx,
   input  logic [31:0] cfg_wdata,
   input  logic        pps_conn,
   input  logic        pps_link,
   input  logic [3:0]  rb_addr,
   output logic [31:0] rb_data
);
   localparam int DATA_W = 32;

   if (SEC_W < 1 || SEC_W > DATA_W) begin : g_bad_sec
      $error("SEC_W must be 1..32");
   end
   if (TICK_W < 2 || TICK_W > DATA_W) begin : g_bad_tick
      $error("TICK_W must be 2..32");
   end

   logic              sec_wr_w, imm_w, pps_evt_w, armed_w;
   logic [SEC_W-1:0]  sec_val_w, now_sec_w, cap_sec_w;
   logic [TICK_W-1:0] tick_val_w, tps_w, now_ticks_w, cap_ticks_w;
   pps_mode_t         mode_w;

   sectick_cfg_regs #(
      .DATA_W(DATA_W), .SEC_W(SEC_W), .TICK_W(TICK_W), .RST_TPS(RST_TPS)
   ) cfg_i (
      .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
      .sec_wr(sec_wr_w), .sec_val(sec_val_w), .tick_val(tick_val_w),
      .imm(imm_w), .tps(tps_w), .mode(mode_w)
   );

   sectick_pps_detect #(.SYNC_STAGES(SYNC_STAGES)) pps_i (
      .clk(clk), .rst(rst), .pins({pps_link, pps_conn}),
      .mode(mode_w), .edge_evt(pps_evt_w)
   );

   sectick_time_core #(.SEC_W(SEC_W), .TICK_W(TICK_W)) core_i (
      .clk(clk), .rst(rst), .sec_wr(sec_wr_w), .sec_val(sec_val_w),
      .tick_val(tick_val_w), .imm(imm_w), .tps(tps_w), .pps_evt(pps_evt_w),
      .now_sec(now_sec_w), .now_ticks(now_ticks_w),
      .cap_sec(cap_sec_w), .cap_ticks(cap_ticks_w), .armed(armed_w)
   );

   always_comb begin
      case (rb_addr[3:2])
         2'd0:    rb_data = DATA_W'(now_sec_w);
         2'd1:    rb_data = DATA_W'(now_ticks_w);
         2'd2:    rb_data = DATA_W'(cap_sec_w);
         default: rb_data = DATA_W'(cap_ticks_w);
      endcase
   end
endmodule

module sectick_checker #(
   parameter int SEC_W  = 32,
   parameter int TICK_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              sec_wr,
   input logic [SEC_W-1:0]  sec_val,
   input logic              imm,
   input logic              pps_evt,
   input logic              armed,
   input logic [SEC_W-1:0]  now_sec,
   input logic [TICK_W-1:0] now_ticks,
   input logic [SEC_W-1:0]  cap_sec,
   input logic [TICK_W-1:0] cap_ticks
);
   // R3
   imm_load_chk: assert property (@(posedge clk) disable iff (rst)
      (sec_wr && imm) |=> (now_sec == $past(sec_val)));
   // R4
   arm_set_chk: assert property (@(posedge clk) disable iff (rst)
      (sec_wr && !imm) |=> armed);
   // R5
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      pps_evt |=> (cap_sec == $past(now_sec) && cap_ticks == $past(now_ticks)));
   // R5
   capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pps_evt |=> ($stable(cap_sec) && $stable(cap_ticks)));
   // R2
   sec_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!sec_wr && !(pps_evt && armed)) |=>
         (now_sec == $past(now_sec) || now_sec == $past(now_sec) + 1'b1));
   // R8
   disarm_chk: assert property (@(posedge clk) disable iff (rst)
      (pps_evt && !sec_wr) |=> !armed);
endmodule

bind sectick_timekeeper sectick_checker #(.SEC_W(SEC_W), .TICK_W(TICK_W)) chk_i (
   .clk(clk), .rst(rst), .sec_wr(sec_wr_w), .sec_val(sec_val_w), .imm(imm_w),
   .pps_evt(pps_evt_w), .armed(armed_w), .now_sec(now_sec_w),
   .now_ticks(now_ticks_w), .cap_sec(cap_sec_w), .cap_ticks(cap_ticks_w)
);

// File: tb/sectick_timekeeper_tb.sv
`timescale 1ns/1ps
module sectick_timekeeper_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        pps_conn = 1'b0;
   logic        pps_link = 1'b0;
   logic [3:0]  rb_addr = '0;
   logic [31:0] rb_data;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sectick_timekeeper #(.RST_TPS(32'd1000)) dut_i (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .pps_conn(pps_conn), .pps_link(pps_link),
      .rb_addr(rb_addr), .rb_data(rb_data)
   );

   typedef struct packed {
      logic [31:0] tps;
      logic [31:0] sec;
      logic [31:0] tk;
      logic [7:0]  n;
      logic [31:0] e_sec;
      logic [31:0] e_tk;
   } vec_t;

   // R2 rollover vectors: immediate load, then n clocks
   localparam vec_t VECS [8] = '{
      '{32'd10, 32'd5,          32'd3,          8'd0,  32'd5,  32'd3},
      '{32'd10, 32'd5,          32'd3,          8'd6,  32'd5,  32'd9},
      '{32'd10, 32'd5,          32'd3,          8'd7,  32'd6,  32'd0},
      '{32'd10, 32'd5,          32'd3,          8'd27, 32'd8,  32'd0},
      '{32'd1,  32'd100,        32'd0,          8'd4,  32'd104, 32'd0},
      '{32'd0,  32'd7,          32'hFFFF_FFFE,  8'd2,  32'd8,  32'd0},
      '{32'd4,  32'hFFFF_FFFF,  32'd2,          8'd2,  32'd0,  32'd0},
      '{32'd10, 32'd20,         32'd15,         8'd1,  32'd21, 32'd0}
   };

   task automatic wr(input logic [2:0] i, input logic [31:0] d);
      cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rb_addr = a;
      #0.2;
      d = rb_data;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_rb(input string tag, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic pulse_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] s, t, cs, ct, d0, d1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_rb("R1 now sec", 4'd0, 32'd0);
      chk_rb("R1 now ticks", 4'd4, 32'd0);
      chk_rb("R1 cap sec", 4'd8, 32'd0);
      chk_rb("R1 cap ticks", 4'd12, 32'd0);
      rst = 1'b0;
      pulse_wait(3);
      chk_rb("R2 count after reset", 4'd4, 32'd3);
      chk_rb("R1 sec after reset", 4'd0, 32'd0);

      // R2 / R3 table walk
      for (int k = 0; k < 8; k++) begin
         wr(3'd4, VECS[k].tps);
         wr(3'd1, VECS[k].tk);
         wr(3'd3, 32'd1);
         wr(3'd0, VECS[k].sec);
         pulse_wait(int'(VECS[k].n));
         chk_rb($sformatf("R2 vec%0d sec", k), 4'd0, VECS[k].e_sec);
         chk_rb($sformatf("R2 vec%0d ticks", k), 4'd4, VECS[k].e_tk);
      end

      // R4 deferred load, rising edge on connector
      wr(3'd4, 32'd1000);
      wr(3'd2, 32'd1);
      wr(3'd3, 32'd1);
      wr(3'd1, 32'd0);
      wr(3'd0, 32'd0);
      chk_rb("R3 immediate load", 4'd4, 32'd0);
      wr(3'd1, 32'd50);
      wr(3'd3, 32'd0);
      wr(3'd0, 32'd77);
      pulse_wait(20);
      chk_rb("R4 pending not applied sec", 4'd0, 32'd0);
      chk_rb("R4 pending not applied ticks", 4'd4, 32'd23);
      pps_conn = 1'b1;
      pulse_wait(3);
      chk_rb("R4 deferred sec", 4'd0, 32'd77);
      chk_rb("R4 deferred ticks", 4'd4, 32'd50);
      chk_rb("R5 cap sec", 4'd8, 32'd0);
      chk_rb("R5 cap ticks", 4'd12, 32'd25);

      // R6 falling edge ignored in rising mode
      pps_conn = 1'b0;
      pulse_wait(3);
      chk_rb("R6 fall ignored", 4'd12, 32'd25);
      chk_rb("R2 ticks continue", 4'd4, 32'd53);

      // R8 second edge captures but does not reload
      pps_conn = 1'b1;
      pulse_wait(3);
      chk_rb("R8 no reload sec", 4'd0, 32'd77);
      chk_rb("R8 no reload ticks", 4'd4, 32'd56);
      chk_rb("R5 cap2 sec", 4'd8, 32'd77);
      chk_rb("R5 cap2 ticks", 4'd12, 32'd55);
      pps_conn = 1'b0;
      pulse_wait(3);

      // R7 source select: link pin, rising
      wr(3'd2, 32'd3);
      pps_conn = 1'b1;
      pulse_wait(3);
      chk_rb("R7 connector ignored", 4'd12, 32'd55);
      pps_conn = 1'b0;
      pulse_wait(3);
      rd(4'd4, t);
      pps_link = 1'b1;
      pulse_wait(3);
      chk_rb("R7 link capture", 4'd12, t + 32'd2);
      pps_link = 1'b0;
      pulse_wait(3);

      // R6 falling mode on connector
      wr(3'd2, 32'd0);
      rd(4'd12, ct);
      pps_conn = 1'b1;
      pulse_wait(3);
      chk_rb("R6 rise ignored in falling mode", 4'd12, ct);
      rd(4'd4, t);
      pps_conn = 1'b0;
      pulse_wait(3);
      chk_rb("R6 falling capture", 4'd12, t + 32'd2);

      // R9 rearm replaces pending
      wr(3'd2, 32'd1);
      wr(3'd1, 32'd0);
      wr(3'd3, 32'd0);
      wr(3'd0, 32'd200);
      wr(3'd0, 32'd300);
      pps_conn = 1'b1;
      pulse_wait(3);
      chk_rb("R9 rearm sec", 4'd0, 32'd300);
      chk_rb("R9 rearm ticks", 4'd4, 32'd0);
      pps_conn = 1'b0;
      pulse_wait(3);

      // R9 immediate cancels pending
      wr(3'd0, 32'd400);
      wr(3'd3, 32'd1);
      wr(3'd0, 32'd500);
      pps_conn = 1'b1;
      pulse_wait(3);
      chk_rb("R9 cancel sec", 4'd0, 32'd500);
      chk_rb("R9 cancel ticks", 4'd4, 32'd3);
      chk_rb("R9 cancel cap", 4'd12, 32'd2);
      pps_conn = 1'b0;
      pulse_wait(3);

      // R10 unused indices
      rd(4'd0, s); rd(4'd4, t); rd(4'd8, cs); rd(4'd12, ct);
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      chk_rb("R10 sec kept", 4'd0, s);
      chk_rb("R10 ticks kept", 4'd4, t + 32'd3);
      chk_rb("R10 cap sec kept", 4'd8, cs);
      chk_rb("R10 cap ticks kept", 4'd12, ct);

      // R11 low address bits ignored
      rd(4'd4, d0); rd(4'd5, d1);
      chk("R11 offset 5 equals 4", d1, d0);
      rd(4'd12, d0); rd(4'd15, d1);
      chk("R11 offset 15 equals 12", d1, d0);
      rd(4'd10, d1);
      chk("R11 offset 10 is cap sec", d1, cs);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule